// File: doc/BRIEF.md
# Multiplexed Bus Cycle Sequencer

This block performs one processor-side bus transfer on a bus whose lines carry the address first and the data afterwards. A requester gives an address, a read/write direction, a memory/IO select and the write data. The sequencer then steps through four clock states, T1, T2, T3 and T4. While the target is not ready it places wait states between T3 and T4.

In T1 the address goes onto the shared lines, and a one-clock address strobe lets an external latch hold it for the rest of the cycle. From T2 onward the shared lines either carry the write data or are released so the target can drive read data. The active-low read or write strobe covers T2, T3 and every wait state. Read data is captured on the last edge before T4, and a one-clock done pulse marks T4. A request can be accepted in T4, so cycles can run back to back with no idle clock between them.

Top module: `bus_cycle_seq`

## Requirements
- R1: With READY high and no waits, a cycle lasts exactly four clocks from the ALE clock to the done clock. A request held high through T4 starts the next T1 on the clock that follows T4.
- R2: ale_o is high only in T1, one clock per cycle. It is never high in T2, T3, a wait state, T4 or idle, and never at the same time as rd_no or wr_no is low.
- R3: In T1, ad_o carries the requested address and ad_oe_o is high. io_sel_o gives the request's memory/IO flag from T1 until the next request is accepted, and is 0 after reset.
- R4: For a write, ad_oe_o stays high from T1 through T4, and from T2 through T4 ad_o carries the write data zero-extended in its low DW bits. For a read, ad_oe_o is low from T2 through T4. Whenever ad_oe_o is low, ad_o is all zeros.
- R5: For a read, rd_no is low in T2, T3 and every wait state. For a write, wr_no is low in those same states. Both strobes are high in T1, T4 and idle, and they are never low together.
- R6: The value of ready_i on the edge that ends T2 decides whether a wait state follows T3: high gives T4, low gives a wait state. The value of ready_i on the edge that ends T3 has no effect.
- R7: In a wait state, ready_i high on the edge that ends it leads to T4, and ready_i low leads to another wait state. The strobes stay asserted throughout and ALE stays low.
- R8: For a read, rdata_o takes ad_i[DW-1:0] as sampled on the edge that ends the last T3 or wait state. It shows that value from T4 on and holds it until the next read capture. A write cycle leaves rdata_o unchanged, and rdata_o is 0 after reset.
- R9: done_o is high for exactly the one T4 clock of each cycle, and never in any other state.
- R10: A request is accepted only in idle or in T4. A request raised during T1, T2, T3 or a wait state and dropped before T4 is ignored: no new T1 follows.
- R11: While rst_ni is low the block is idle, with ale_o=0, rd_no=1, wr_no=1, ad_oe_o=0, done_o=0 and rdata_o=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Transfer request |
| req_we_i | input | 1 | 1 = write, 0 = read |
| req_io_i | input | 1 | 1 = IO space, 0 = memory space |
| req_addr_i | input | AW | Transfer address |
| req_wdata_i | input | DW | Write data |
| ready_i | input | 1 | Target ready, high ends waiting |
| ad_i | input | AW | Shared lines as seen from the bus |
| ad_o | output | AW | Value driven onto the shared lines |
| ad_oe_o | output | 1 | Drive enable for the shared lines |
| ale_o | output | 1 | Address latch strobe, high in T1 |
| rd_no | output | 1 | Read strobe, active low |
| wr_no | output | 1 | Write strobe, active low |
| io_sel_o | output | 1 | Memory/IO select of the current cycle |
| rdata_o | output | DW | Captured read data |
| done_o | output | 1 | High in T4 |

## Verification
The hard cases lie in how READY is sampled. Only the edge ending T2 counts for the first decision, and after that only the edges ending wait states. A target that is late at T2 but ready during T3 must still cost one wait state. A target that is ready at T2 but not during T3 must cost none. The bench produces these and longer runs of waits by deriving ready_i from the current cycle phase in its own model. It also draws ad_i at random on every clock, so a capture taken one clock early or late shows up as a wrong value. A request is raised and dropped in mid-cycle to show it is ignored, and a request is held across T4 to force back-to-back cycles.

// File: rtl/bus_seq_pkg.sv
package bus_seq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_T1   = 3'd1,
    ST_T2   = 3'd2,
    ST_T3   = 3'd3,
    ST_TW   = 3'd4,
    ST_T4   = 3'd5
  } bus_state_e;
endpackage

// File: rtl/bus_seq_fsm.sv
module bus_seq_fsm
  import bus_seq_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       req_i,
  input  logic       ready_i,
  output bus_state_e state_o,
  output logic       accept_o,
  output logic       capture_o
);
  bus_state_e state_q, state_d;
  logic       rdy_q;  // READY seen on the edge that ends T2

  assign state_o   = state_q;
  assign accept_o  = req_i && (state_q == ST_IDLE || state_q == ST_T4);
  assign capture_o = (state_q == ST_T3 && rdy_q) || (state_q == ST_TW && ready_i);

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE: state_d = accept_o ? ST_T1 : ST_IDLE;
      ST_T1:   state_d = ST_T2;
      ST_T2:   state_d = ST_T3;
      ST_T3:   state_d = rdy_q ? ST_T4 : ST_TW;
      ST_TW:   state_d = ready_i ? ST_T4 : ST_TW;
      ST_T4:   state_d = accept_o ? ST_T1 : ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      rdy_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      if (state_q == ST_T2) rdy_q <= ready_i;
    end
  end

  // R6: ready seen at the end of T2 picks the state after T3
  p_t2_ready_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_T2 && ready_i) |=> ##1 (state_q == ST_T4));
  p_t2_wait_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_T2 && !ready_i) |=> ##1 (state_q == ST_TW));
  // R7: a wait state repeats while ready is low
  p_wait_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_TW && !ready_i) |=> (state_q == ST_TW));
  // R10: no new cycle starts from mid-cycle states
  p_no_midcycle_start_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q inside {ST_T1, ST_T2, ST_T3, ST_TW}) |=> (state_q != ST_T1));
endmodule

// File: rtl/bus_seq_drive.sv
module bus_seq_drive
  import bus_seq_pkg::*;
#(
  parameter int AW = 20,
  parameter int DW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  bus_state_e    state_i,
  input  logic          accept_i,
  input  logic          req_we_i,
  input  logic          req_io_i,
  input  logic [AW-1:0] req_addr_i,
  input  logic [DW-1:0] req_wdata_i,
  output logic [AW-1:0] ad_o,
  output logic          ad_oe_o,
  output logic          ale_o,
  output logic          rd_no,
  output logic          wr_no,
  output logic          io_sel_o,
  output logic          done_o,
  output logic          we_o
);
  logic [AW-1:0] addr_q;
  logic [DW-1:0] wdata_q;
  logic          we_q, io_q;
  logic [AW-1:0] wext;
  logic          data_ph, strobe_ph;

  generate
    if (AW > DW) begin : g_pad
      assign wext = {{(AW-DW){1'b0}}, wdata_q};
    end else begin : g_nopad
      assign wext = wdata_q[AW-1:0];
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q  <= '0;
      wdata_q <= '0;
      we_q    <= 1'b0;
      io_q    <= 1'b0;
    end else if (accept_i) begin
      addr_q  <= req_addr_i;
      wdata_q <= req_wdata_i;
      we_q    <= req_we_i;
      io_q    <= req_io_i;
    end
  end

  assign data_ph   = state_i inside {ST_T2, ST_T3, ST_TW, ST_T4};
  assign strobe_ph = state_i inside {ST_T2, ST_T3, ST_TW};

  assign ale_o    = (state_i == ST_T1);
  assign ad_oe_o  = ale_o || (we_q && data_ph);
  assign ad_o     = ale_o ? addr_q : ((we_q && data_ph) ? wext : '0);
  assign rd_no    = !(strobe_ph && !we_q);
  assign wr_no    = !(strobe_ph && we_q);
  assign io_sel_o = io_q;
  assign done_o   = (state_i == ST_T4);
  assign we_o     = we_q;

  p_ale_quiet_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ale_o |-> (rd_no && wr_no && !done_o));
  p_ale_pulse_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ale_o |=> !ale_o);
  p_strobe_excl_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_no || wr_no));
  p_write_drive_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_no |-> ad_oe_o);
  p_read_release_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_no |-> (!ad_oe_o && ad_o == '0));
endmodule

// File: rtl/bus_seq_rcap.sv
module bus_seq_rcap #(
  parameter int AW = 20,
  parameter int DW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          capture_i,
  input  logic          we_i,
  input  logic [AW-1:0] ad_i,
  output logic [DW-1:0] rdata_o
);
  logic [DW-1:0] rdata_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                rdata_q <= '0;
    else if (capture_i && !we_i) rdata_q <= ad_i[DW-1:0];
  end

  assign rdata_o = rdata_q;

  p_capture_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (capture_i && !we_i) |=> (rdata_o == $past(ad_i[DW-1:0])));
  p_write_keeps_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> $stable(rdata_o));
endmodule

// File: rtl/bus_cycle_seq.sv
module bus_cycle_seq
  import bus_seq_pkg::*;
#(
  parameter int AW = 20,
  parameter int DW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_i,
  input  logic          req_we_i,
  input  logic          req_io_i,
  input  logic [AW-1:0] req_addr_i,
  input  logic [DW-1:0] req_wdata_i,
  input  logic          ready_i,
  input  logic [AW-1:0] ad_i,
  output logic [AW-1:0] ad_o,
  output logic          ad_oe_o,
  output logic          ale_o,
  output logic          rd_no,
  output logic          wr_no,
  output logic          io_sel_o,
  output logic [DW-1:0] rdata_o,
  output logic          done_o
);
  bus_state_e state;
  logic       accept, capture, we;

  bus_seq_fsm u_fsm (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .req_i     (req_i),
    .ready_i   (ready_i),
    .state_o   (state),
    .accept_o  (accept),
    .capture_o (capture)
  );

  bus_seq_drive #(.AW(AW), .DW(DW)) u_drive (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .state_i     (state),
    .accept_i    (accept),
    .req_we_i    (req_we_i),
    .req_io_i    (req_io_i),
    .req_addr_i  (req_addr_i),
    .req_wdata_i (req_wdata_i),
    .ad_o        (ad_o),
    .ad_oe_o     (ad_oe_o),
    .ale_o       (ale_o),
    .rd_no       (rd_no),
    .wr_no       (wr_no),
    .io_sel_o    (io_sel_o),
    .done_o      (done_o),
    .we_o        (we)
  );

  bus_seq_rcap #(.AW(AW), .DW(DW)) u_rcap (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .capture_i (capture),
    .we_i      (we),
    .ad_i      (ad_i),
    .rdata_o   (rdata_o)
  );

  p_done_single_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  p_done_after_strobe_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (rd_no && wr_no && !ale_o));
  p_t1_addr_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ale_o |-> ad_oe_o);
  p_ale_next_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ale_o |=> (!rd_no || !wr_no));
endmodule

// File: tb/tb_bus_cycle_seq.sv
`timescale 1ns/1ps
module tb_bus_cycle_seq;
  localparam int AW = 20;
  localparam int DW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req = 1'b0, req_we = 1'b0, req_io = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic          ready_i = 1'b1;
  logic [AW-1:0] ad_in = '0;
  logic [AW-1:0] ad_o;
  logic          ad_oe, ale, rd_n, wr_n, io_sel, done;
  logic [DW-1:0] rdata;

  always #5 clk = ~clk;

  bus_cycle_seq #(.AW(AW), .DW(DW)) dut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .req_we_i(req_we), .req_io_i(req_io),
    .req_addr_i(req_addr), .req_wdata_i(req_wdata), .ready_i(ready_i), .ad_i(ad_in),
    .ad_o(ad_o), .ad_oe_o(ad_oe), .ale_o(ale), .rd_no(rd_n), .wr_no(wr_n),
    .io_sel_o(io_sel), .rdata_o(rdata), .done_o(done)
  );

  int n_chk = 0, n_fail = 0;
  task automatic chk(input bit ok, input string rq, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
    end
  endtask

  // Reference model: phase 0 idle, 1 T1, 2 T2, 3 T3, 4 Tw, 5 T4
  int            m_phase = 0;
  bit            m_rdy2 = 0, m_we = 0, m_io = 0;
  logic [AW-1:0] m_addr = '0;
  logic [DW-1:0] m_wdata = '0, m_rdata = '0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_phase = 0; m_rdy2 = 0; m_we = 0; m_io = 0;
      m_addr = '0; m_wdata = '0; m_rdata = '0;
    end else begin
      int nxt;
      nxt = m_phase;
      if (m_phase == 0 || m_phase == 5) begin
        if (req) begin
          nxt = 1; m_we = req_we; m_io = req_io; m_addr = req_addr; m_wdata = req_wdata;
        end else nxt = 0;
      end else if (m_phase == 1) nxt = 2;
      else if (m_phase == 2) begin m_rdy2 = ready_i; nxt = 3; end
      else if (m_phase == 3 || m_phase == 4) begin
        bit go;
        go = (m_phase == 3) ? m_rdy2 : ready_i;
        if (go) begin
          if (!m_we) m_rdata = ad_in[DW-1:0];
          nxt = 5;
        end else nxt = 4;
      end
      m_phase = nxt;
    end
  end

  // Cycle-by-cycle comparison, away from the active edge
  int len = 0, last_len = 0;
  always @(negedge clk) begin
    logic          e_oe, e_rd, e_wr;
    logic [AW-1:0] e_ad;
    bit            dph;
    dph  = (m_phase >= 2 && m_phase <= 5);
    e_oe = (m_phase == 1) || (m_we && dph);
    e_ad = (m_phase == 1) ? m_addr : ((m_we && dph) ? AW'(m_wdata) : '0);
    e_rd = !(!m_we && m_phase >= 2 && m_phase <= 4);
    e_wr = !(m_we && m_phase >= 2 && m_phase <= 4);
    chk(ale === (m_phase == 1), "R2", "ale_o", 32'(ale), 32'(m_phase == 1));
    chk(ad_oe === e_oe, "R4", "ad_oe_o", 32'(ad_oe), 32'(e_oe));
    chk(ad_o === e_ad, (m_phase == 1) ? "R3" : "R4", "ad_o", 32'(ad_o), 32'(e_ad));
    chk(rd_n === e_rd, "R5", "rd_no", 32'(rd_n), 32'(e_rd));
    chk(wr_n === e_wr, "R5", "wr_no", 32'(wr_n), 32'(e_wr));
    chk(done === (m_phase == 5), "R9", "done_o", 32'(done), 32'(m_phase == 5));
    chk(io_sel === m_io, "R3", "io_sel_o", 32'(io_sel), 32'(m_io));
    chk(rdata === m_rdata, "R8", "rdata_o", 32'(rdata), 32'(m_rdata));
    if (ale) len = 1;
    else if (len > 0) len++;
    if (done) begin last_len = len; len = 0; end
  end

  // Stimulus for ready_i and the bus value, derived from the model phase
  int rdy_mode = 0, wcnt = 0;
  always @(negedge clk) begin
    ad_in <= AW'($urandom);
    if (m_phase == 1) wcnt = 0;
    case (rdy_mode)
      0: ready_i <= 1'b1;
      1: ready_i <= ($urandom % 3) != 0;
      3: ready_i <= (m_phase != 2);               // late at T2, ready during T3
      4: ready_i <= (m_phase == 2);               // ready at T2 only
      5: ready_i <= !(m_phase == 2 || (m_phase == 4 && wcnt < 2));
      default: ready_i <= 1'b1;
    endcase
    if (m_phase == 4) wcnt++;
  end

  task automatic issue(input bit we, input bit io, input logic [AW-1:0] a,
                       input logic [DW-1:0] d);
    req = 1'b1; req_we = we; req_io = io; req_addr = a; req_wdata = d;
    do @(negedge clk); while (m_phase != 1);
    req = 1'b0;
  endtask

  task automatic wait_done();
    do @(negedge clk); while (!done);
    @(negedge clk);
  endtask

  initial begin
    logic [DW-1:0] keep;
    repeat (3) @(negedge clk);
    chk(ale === 1'b0, "R11", "reset ale_o", 32'(ale), 0);
    chk(rd_n === 1'b1 && wr_n === 1'b1, "R11", "reset strobes", {rd_n, wr_n}, 3);
    chk(ad_oe === 1'b0, "R11", "reset ad_oe_o", 32'(ad_oe), 0);
    chk(done === 1'b0, "R11", "reset done_o", 32'(done), 0);
    chk(rdata === '0, "R11", "reset rdata_o", 32'(rdata), 0);
    rst_n = 1'b1;
    @(negedge clk);

    rdy_mode = 0;
    issue(1, 0, 20'h12345, 16'hbeef); wait_done();
    chk(last_len == 4, "R1", "write length", last_len, 4);
    issue(0, 0, 20'h0abcd, 16'h0); wait_done();
    chk(last_len == 4, "R1", "read length", last_len, 4);
    issue(0, 1, 20'hfff00, 16'h0); wait_done();
    chk(last_len == 4, "R1", "io read length", last_len, 4);

    // back to back: second request held through T4
    issue(1, 1, 20'h00010, 16'h1111);
    issue(0, 0, 20'h00020, 16'h0);
    chk(ale === 1'b1, "R10", "T1 right after T4", 32'(ale), 1);
    wait_done();
    chk(last_len == 4, "R1", "back-to-back length", last_len, 4);

    rdy_mode = 3;
    issue(0, 0, 20'h33333, 16'h0); wait_done();
    chk(last_len == 5, "R6", "late at T2 gives one wait", last_len, 5);
    rdy_mode = 4;
    issue(0, 0, 20'h44444, 16'h0); wait_done();
    chk(last_len == 4, "R6", "ready low in T3 ignored", last_len, 4);
    rdy_mode = 5;
    issue(1, 0, 20'h55555, 16'h5a5a); wait_done();
    chk(last_len == 7, "R7", "three waits on write", last_len, 7);
    issue(0, 1, 20'h66666, 16'h0); wait_done();
    chk(last_len == 7, "R7", "three waits on read", last_len, 7);

    // write leaves captured data alone
    rdy_mode = 0;
    keep = rdata;
    issue(1, 0, 20'h77777, 16'hc0de); wait_done();
    chk(rdata === keep, "R8", "rdata after write", 32'(rdata), 32'(keep));

    // request pulsed mid-cycle is ignored
    issue(0, 0, 20'h88888, 16'h0);
    @(negedge clk);
    req = 1'b1; req_we = 1'b1; req_addr = 20'h99999;
    @(negedge clk);
    req = 1'b0;
    wait_done();
    chk(ale === 1'b0, "R10", "no T1 after mid-cycle request", 32'(ale), 0);
    chk(done === 1'b0, "R10", "idle after mid-cycle request", 32'(done), 0);

    rdy_mode = 1;
    for (int i = 0; i < 40; i++) begin
      issue(1'($urandom), 1'($urandom), AW'($urandom), DW'($urandom));
      repeat ($urandom % 8) @(negedge clk);
    end
    rdy_mode = 0;
    repeat (40) @(negedge clk);
    chk(m_phase == 0 && !done, "R9", "final idle", 32'(m_phase), 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #1_000_000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule